// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides a fast input clock by a programmable integer ratio N of up to 15 bits. Each output period is built from an 8/9 dual-modulus prescaler, a 3-bit swallow counter and a 12-bit main counter. The low three bits of the ratio word set the swallow count A and the high twelve bits set the main count M. The prescaler divides by 9 for the first A of its cycles in each output period, then by 8 for the remaining M−A cycles. The output period is therefore 8·M + A input clocks, and the ratio can step by a single input clock.

A new ratio is written into a staging register. Any value below 56 is raised to 56 on the way in. The counters read the staged value only when the current output period ends, so a period is never cut short or stretched. The divided output is a single-clock pulse at each terminal count, which feeds a phase comparator. A second output toggles on every pulse, giving the divided frequency halved for observation on a test pin. The prescaler is modelled as synchronous logic on the input clock.

Top module: `pswallow_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` and `div_half` are 0. After reset the staged ratio is 56, and the first `div_pulse` is high after exactly 55 rising clock edges following the release of reset.
- R2: With a staged ratio N in 56..32767, the distance between consecutive `div_pulse` assertions is exactly N clock cycles, including the maximum 32767.
- R3: The ratio word maps bits [14:3] to the main count M and bits [2:0] to the swallow count A. The prescaler runs in its divide-by-9 mode only during the first A prescaler cycles of an output period, so every A value 0..7 yields a period of 8·M + A.
- R4: `div_pulse` is high for exactly one clock cycle per output period, and only on a prescaler wrap.
- R5: `div_half` inverts on the clock edge that ends each `div_pulse` cycle and holds its value otherwise.
- R6: A written ratio below 56 (including 0) is stored as 56, so the main count loaded is never below 7.
- R7: A ratio write that occurs in the middle of an output period leaves that period's length unchanged. The new ratio governs the next period.
- R8: A ratio write sampled on the same edge as a terminal count does not affect the period starting at that edge. It governs the period after that one.
- R9: When several writes land within one output period, the last one written governs the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_wr | input | 1 | Strobe that captures `ratio_word` into the staging register |
| ratio_word | input | 15 | Requested division ratio: [14:3] main count, [2:0] swallow count |
| div_pulse | output | 1 | One-clock pulse at each terminal count |
| div_half | output | 1 | Level that toggles on every `div_pulse` (divided output halved) |

## Verification
A write to the staging register and the terminal-count reload of the counters can fall on the same clock edge. The reload must then take the value that was staged before that edge. The bench provokes this collision by raising `ratio_wr` in the very cycle in which it observes `div_pulse` high. It then measures the next two pulse intervals: the first must still equal the old ratio, and only the second may equal the new one. Writes in mid-period and back-to-back writes within one period are also timed against the period boundaries, and each measured interval is compared with the clamped ratio computed in the bench.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // Prescaler modulus selection.
  typedef enum logic {
    MOD_LOW  = 1'b0,   // divide by 2**SWALLOW_W
    MOD_HIGH = 1'b1    // divide by 2**SWALLOW_W + 1
  } modulus_e;

  localparam int DEF_RATIO_W   = 15;
  localparam int DEF_SWALLOW_W = 3;
  localparam int DEF_MIN_RATIO = 56;

endpackage

// File: rtl/pswallow_stage.sv
module pswallow_stage #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 56
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [RATIO_W-1:0] word_in,
  output logic [RATIO_W-1:0] staged
);

  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

  // Raises an illegal small ratio to the legal floor.
  function automatic logic [RATIO_W-1:0] legalize(input logic [RATIO_W-1:0] r);
    return (r < FLOOR) ? FLOOR : r;
  endfunction

  logic [RATIO_W-1:0] accepted;

  generate
    if (MIN_RATIO > 0) begin : g_clamp
      assign accepted = legalize(word_in);
    end else begin : g_pass
      assign accepted = word_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  staged <= FLOOR;
    else if (wr) staged <= accepted;
  end

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
#(
  parameter int LOW_MOD = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  modulus_e mod_sel,
  output logic     wrap
);

  localparam int CNT_W = $clog2(LOW_MOD + 1);
  localparam logic [CNT_W-1:0] LAST_LOW  = CNT_W'(LOW_MOD - 1);
  localparam logic [CNT_W-1:0] LAST_HIGH = CNT_W'(LOW_MOD);

  logic [CNT_W-1:0] phase;

  assign wrap = (phase == ((mod_sel == MOD_HIGH) ? LAST_HIGH : LAST_LOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (wrap) phase <= '0;
    else           phase <= phase + 1'b1;
  end

endmodule

// File: rtl/pswallow_ctrl.sv
module pswallow_ctrl
  import pswallow_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int SWALLOW_W = 3,
  parameter int MIN_RATIO = 56
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          psc_wrap,
  input  logic [RATIO_W-1:0]            next_ratio,
  output modulus_e                      mod_sel,
  output logic                          terminal,
  output logic [RATIO_W-SWALLOW_W-1:0]  main_cnt
);

  localparam int MAIN_W = RATIO_W - SWALLOW_W;
  localparam logic [MAIN_W-1:0]    RST_MAIN = MAIN_W'(MIN_RATIO >> SWALLOW_W);
  localparam logic [SWALLOW_W-1:0] RST_SWAL = SWALLOW_W'(MIN_RATIO % (2 ** SWALLOW_W));
  localparam logic [MAIN_W-1:0]    ONE_MAIN = MAIN_W'(1);

  logic [SWALLOW_W-1:0] swal_cnt;
  logic [MAIN_W-1:0]    load_main;
  logic [SWALLOW_W-1:0] load_swal;

  assign load_main = next_ratio[RATIO_W-1:SWALLOW_W];
  assign load_swal = next_ratio[SWALLOW_W-1:0];

  assign mod_sel  = (swal_cnt != '0) ? MOD_HIGH : MOD_LOW;
  assign terminal = psc_wrap && (main_cnt == ONE_MAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_cnt <= RST_MAIN;
      swal_cnt <= RST_SWAL;
    end else if (terminal) begin
      main_cnt <= load_main;
      swal_cnt <= load_swal;
    end else if (psc_wrap) begin
      main_cnt <= main_cnt - 1'b1;
      if (swal_cnt != '0) swal_cnt <= swal_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int RATIO_W   = DEF_RATIO_W,
  parameter int SWALLOW_W = DEF_SWALLOW_W,
  parameter int MIN_RATIO = DEF_MIN_RATIO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_wr,
  input  logic [RATIO_W-1:0] ratio_word,
  output logic               div_pulse,
  output logic               div_half
);

  localparam int MAIN_W  = RATIO_W - SWALLOW_W;
  localparam int LOW_MOD = 2 ** SWALLOW_W;

  logic [RATIO_W-1:0] staged_ratio;
  logic               psc_wrap;
  modulus_e           mod_sel;
  logic               terminal;
  logic [MAIN_W-1:0]  main_cnt;

  pswallow_stage #(
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ratio_wr),
    .word_in(ratio_word),
    .staged (staged_ratio)
  );

  pswallow_prescaler #(
    .LOW_MOD(LOW_MOD)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .mod_sel(mod_sel),
    .wrap   (psc_wrap)
  );

  pswallow_ctrl #(
    .RATIO_W  (RATIO_W),
    .SWALLOW_W(SWALLOW_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .psc_wrap  (psc_wrap),
    .next_ratio(staged_ratio),
    .mod_sel   (mod_sel),
    .terminal  (terminal),
    .main_cnt  (main_cnt)
  );

  assign div_pulse = terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_half <= 1'b0;
    else if (terminal) div_half <= ~div_half;
  end

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk
  import pswallow_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int SWALLOW_W = 3,
  parameter int MIN_RATIO = 56
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ratio_wr,
  input logic                         div_pulse,
  input logic                         div_half,
  input logic                         psc_wrap,
  input modulus_e                     mod_sel,
  input logic [RATIO_W-SWALLOW_W-1:0] main_cnt,
  input logic [RATIO_W-1:0]           staged_ratio
);

  localparam int MAIN_W = RATIO_W - SWALLOW_W;
  localparam logic [MAIN_W-1:0]  MIN_MAIN  = MAIN_W'(MIN_RATIO >> SWALLOW_W);
  localparam logic [RATIO_W-1:0] MIN_WORD  = RATIO_W'(MIN_RATIO);

  // R4: pulse lasts a single cycle
  a_r4_pulse_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R4: pulse only coincides with a prescaler wrap
  a_r4_pulse_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> psc_wrap);

  // R5: halved output flips after each pulse
  a_r5_half_flips: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> (div_half != $past(div_half)));

  // R5: halved output holds between pulses
  a_r5_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |=> $stable(div_half));

  // R3: once in divide-by-8 mode, stays there until the period ends
  a_r3_swallow_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_sel == MOD_LOW && !div_pulse) |=> (mod_sel == MOD_LOW));

  // R3: modulus only changes at a prescaler boundary
  a_r3_mod_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !psc_wrap |=> $stable(mod_sel));

  // R6: reload never brings a main count below the legal floor
  a_r6_load_legal: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> (main_cnt >= MIN_MAIN));

  // R6: staged word is always legal after a write
  a_r6_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> (staged_ratio >= MIN_WORD));

endmodule

bind pswallow_div pswallow_div_chk #(
  .RATIO_W  (RATIO_W),
  .SWALLOW_W(SWALLOW_W),
  .MIN_RATIO(MIN_RATIO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ratio_wr    (ratio_wr),
  .div_pulse   (div_pulse),
  .div_half    (div_half),
  .psc_wrap    (psc_wrap),
  .mod_sel     (mod_sel),
  .main_cnt    (main_cnt),
  .staged_ratio(staged_ratio)
);

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps
module pswallow_div_bench;

  localparam int NV       = 12;
  localparam int WD_LIMIT = 40000;
  localparam int CYC_MAX  = 190000;

  // {tag, ratio written, expected interval}
  localparam logic [33:0] VEC [NV] = '{
    {4'd2, 15'd56,    15'd56},     // R2 minimum legal ratio
    {4'd2, 15'd57,    15'd57},     // R2 single-step above minimum
    {4'd3, 15'd63,    15'd63},     // R3 swallow count 7
    {4'd2, 15'd64,    15'd64},     // R2 swallow count 0
    {4'd3, 15'd71,    15'd71},     // R3 M=8, A=7
    {4'd2, 15'd100,   15'd100},    // R2
    {4'd6, 15'd0,     15'd56},     // R6 zero clamps
    {4'd6, 15'd10,    15'd56},     // R6 small value clamps
    {4'd6, 15'd55,    15'd56},     // R6 one below floor
    {4'd3, 15'd1023,  15'd1023},   // R3 M=127, A=7
    {4'd2, 15'd1000,  15'd1000},   // R2
    {4'd2, 15'd32767, 15'd32767}   // R2 maximum ratio
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio_wr = 1'b0;
  logic [14:0] ratio_word = '0;
  logic        div_pulse;
  logic        div_half;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  pswallow_div u_pswallow_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_wr  (ratio_wr),
    .ratio_word(ratio_word),
    .div_pulse (div_pulse),
    .div_half  (div_half)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > CYC_MAX) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, CYC_MAX);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until the next pulse; optional writes at given offsets.
  task automatic run_period(input bit chk, input int at1, input logic [14:0] v1,
                            input int at2, input logic [14:0] v2, output int n);
    logic h0;
    h0 = div_half;
    n = 0;
    do begin
      if (n == at1) begin ratio_wr = 1'b1; ratio_word = v1; end
      else if (n == at2) begin ratio_wr = 1'b1; ratio_word = v2; end
      @(negedge clk);
      n++;
      ratio_wr = 1'b0;
      if (chk && n == 1) begin
        check("R4 pulse width", int'(div_pulse), 0);
        check("R5 half toggle", int'(div_half), int'(!h0));
      end
    end while (!div_pulse && n < WD_LIMIT);
  endtask

  initial begin
    int n;
    logic [3:0]  tag;
    logic [14:0] r;
    logic [14:0] e;

    repeat (3) @(negedge clk);
    check("R1 pulse low in reset", int'(div_pulse), 0);
    check("R1 half low in reset", int'(div_half), 0);
    rst_n = 1'b1;
    run_period(1'b0, -1, '0, -1, '0, n);
    check("R1 first pulse after 55 edges", n, 55);

    for (int i = 0; i < NV; i++) begin
      tag = VEC[i][33:30];
      r   = VEC[i][29:15];
      e   = VEC[i][14:0];
      run_period(1'b1, 1, r, -1, '0, n);
      run_period(1'b1, -1, '0, -1, '0, n);
      check($sformatf("R%0d interval for ratio %0d", tag, r), n, int'(e));
    end

    // Directed: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pulse low in second reset", int'(div_pulse), 0);
    check("R1 half low in second reset", int'(div_half), 0);
    rst_n = 1'b1;
    run_period(1'b0, 1, 15'd100, -1, '0, n);
    check("R1 default period after reset", n, 55);
    run_period(1'b1, -1, '0, -1, '0, n);
    check("R7 baseline 100", n, 100);

    // R7: mid-period write keeps current period
    run_period(1'b1, 20, 15'd70, -1, '0, n);
    check("R7 current period kept", n, 100);
    run_period(1'b1, -1, '0, -1, '0, n);
    check("R7 new ratio applied next", n, 70);

    // R8: write on the terminal edge
    run_period(1'b1, 0, 15'd80, -1, '0, n);
    check("R8 coincident write not yet used", n, 70);
    run_period(1'b1, -1, '0, -1, '0, n);
    check("R8 coincident write used one period later", n, 80);

    // R9: two writes in one period
    run_period(1'b1, 5, 15'd200, 30, 15'd90, n);
    check("R9 period during writes", n, 80);
    run_period(1'b1, -1, '0, -1, '0, n);
    check("R9 last write wins", n, 90);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule